// File: doc/BRIEF.md
# Coprocessor Access Trap Classifier

This block decides, in the same cycle, whether an access made from non-secure state has to trap to the hypervisor. The access can be a floating-point or SIMD instruction, a register-bank access, a read or write of a trace system register, an activity-monitor register, or the lower-level access control register. It takes the hypervisor's 32-bit trap control word, the override bits that a secure access-control register supplies, a flag showing that a lower-level or secure control already trapped the access, the current exception level, a class code for the access and a flag for two-register transfers.

The outputs are a trap flag, the kind of exception and a syndrome class. The kind is either a hypervisor trap or an undefined-instruction exception taken at level 2. The exception entry logic uses these outputs. This block does not take the exception itself.

The trap control word keeps its bit positions, because the register that stores it decodes the same fields. Bit 10 traps all floating-point and SIMD work. Bit 11 is a copy with no effect. Bit 15 traps SIMD-only instructions. Bit 20 traps trace registers. Bit 30 traps activity monitors. Bit 31 traps the lower-level access control register.

Top module: `cpt_trap_classifier`

## Requirements
- R1: With accClass 1 (floating-point/SIMD common work) and trapCtl bit 10 set, a non-secure access from level 0 or 1 gives trapOut=1, kindOut=0, syndOut=0x07. With bit 10 clear and no override active, accClass 1 does not trap.
- R2: With accClass 2 (SIMD-only instruction), the access traps with syndrome 0x07 when bit 15 is set and bit 10 is clear. When bit 10 is set it traps whatever bit 15 holds. Bit 15 alone never traps accClass 1.
- R3: trapCtl bit 11 has no effect on any output, for every class and level.
- R4: With accClass 3 (trace register) and bit 20 set, an access from level 1 or 2 traps. A level-1 access reports syndrome 0x05 when pairXfer=0 and 0x0C when pairXfer=1. An access from level 0 never traps, because the undefined case takes priority.
- R5: With accClass 4 (activity monitor) and bit 30 set, an access from level 0 or 1 traps with syndrome 0x03, or 0x04 when pairXfer=1. A level-2 access does not trap. Trap bits other than bit 30 do not trap this class.
- R6: With accClass 5 (lower-level access control register) and bit 31 set, only a level-1 access traps, with syndrome 0x03.
- R7: When lowerTrap=1, trapOut is 0, whatever the trap bits and overrides hold.
- R8: A trap from level 0 or 1 reports kindOut=0 (hypervisor trap) with its class. A trap from level 2 reports kindOut=1 (undefined instruction at level 2) with syndOut=0x00.
- R9: When nonSecure=1 and secLvl3Narrow=1, the following effective bits read as one: bit 10 and bit 11 when cp10Grant=0, bit 15 when simdDeny=1, and bit 20 when traceDeny=1. When secLvl3Narrow=0 these overrides have no effect.
- R10: A secure request (nonSecure=0), a level-3 request, or accClass 0 (none) gives trapOut=0, kindOut=0 and syndOut=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| nonSecure | input | 1 | The request comes from non-secure state |
| curLevel | input | 2 | Current exception level, 0 to 3 |
| accClass | input | 3 | Access class: 0 none, 1 FP/SIMD common, 2 SIMD-only, 3 trace, 4 activity monitor, 5 access control register |
| pairXfer | input | 1 | The access is a two-register transfer |
| trapCtl | input | 32 | Hypervisor trap control word |
| secLvl3Narrow | input | 1 | Level 3 is present and uses the 32-bit state |
| cp10Grant | input | 1 | Secure grant for FP/SIMD. When 0 it forces bits 10 and 11 |
| simdDeny | input | 1 | Secure SIMD disable. When 1 it forces bit 15 |
| traceDeny | input | 1 | Secure trace disable. When 1 it forces bit 20 |
| lowerTrap | input | 1 | A lower-level or secure control already traps this access |
| trapOut | output | 1 | The access traps to the hypervisor |
| kindOut | output | 1 | 0 hypervisor trap, 1 undefined instruction at level 2 |
| syndOut | output | 6 | Syndrome class, or 0 when there is no trap or kindOut=1 |

## Verification
The bench targets the interactions between fields:
- Bit 15 is tested under bit 10, which makes it irrelevant. A design that gates bit 15 wrongly either misses SIMD-only traps or traps common FP work.
- Bit 11 is toggled against every class and level, to catch a design that gives it meaning.
- The level limits are tested for each class: trace from level 0, monitors from level 2, and the control register from levels 0 and 2. A design that widens a level window raises traps there.
- The secure overrides are applied with and without the level-3 qualifier, and from secure state. Lower-level traps are applied on top of active trap bits.
- The syndrome selection by transfer width is checked, as is the forced zero syndrome on a level-2 undefined exception.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  localparam int SYND_W = 6;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_FP    = 3'd1,
    CLS_SIMD  = 3'd2,
    CLS_TRACE = 3'd3,
    CLS_AMU   = 3'd4,
    CLS_ACC   = 3'd5
  } cpt_class_e;

  localparam logic [SYND_W-1:0] SYN_NONE     = 6'h00;
  localparam logic [SYND_W-1:0] SYN_FPSIMD   = 6'h07;
  localparam logic [SYND_W-1:0] SYN_MOVE1    = 6'h03;
  localparam logic [SYND_W-1:0] SYN_MOVE2    = 6'h04;
  localparam logic [SYND_W-1:0] SYN_TRACE1   = 6'h05;
  localparam logic [SYND_W-1:0] SYN_TRACE2   = 6'h0C;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic allow;
    logic fromHyp;
    logic wide;
    logic selFp;
    logic selSimd;
    logic selTrace;
    logic selAmu;
    logic selAcc;
    logic forceFp;
    logic forceSimd;
    logic forceTrace;
  } cpt_strobe_t;

endpackage

// File: rtl/cpt_trap_ctrl.sv
module cpt_trap_ctrl
  import cpt_pkg::*;
(
  input  logic        nonSecure,
  input  logic [1:0]  curLevel,
  input  logic [2:0]  accClass,
  input  logic        pairXfer,
  input  logic        secLvl3Narrow,
  input  logic        cp10Grant,
  input  logic        simdDeny,
  input  logic        traceDeny,
  input  logic        lowerTrap,
  output cpt_strobe_t stb
);

  logic isLvl0, isLvl1, isLvl2, isLvl3;
  logic forceOn;

  assign isLvl0  = (curLevel == 2'd0);
  assign isLvl1  = (curLevel == 2'd1);
  assign isLvl2  = (curLevel == 2'd2);
  assign isLvl3  = (curLevel == 2'd3);
  assign forceOn = nonSecure & secLvl3Narrow;

  always_comb begin
    stb         = '0;
    // traps raised elsewhere outrank everything decided here
    stb.allow   = nonSecure & ~lowerTrap & ~isLvl3;
    stb.fromHyp = isLvl2;
    stb.wide    = pairXfer;
    unique case (cpt_class_e'(accClass))
      CLS_FP:    stb.selFp    = 1'b1;
      CLS_SIMD:  stb.selSimd  = 1'b1;
      // level-0 trace access is undefined, which outranks the trap
      CLS_TRACE: stb.selTrace = isLvl1 | isLvl2;
      CLS_AMU:   stb.selAmu   = isLvl0 | isLvl1;
      CLS_ACC:   stb.selAcc   = isLvl1;
      default:   ;
    endcase
    stb.forceFp    = forceOn & ~cp10Grant;
    stb.forceSimd  = forceOn & simdDeny;
    stb.forceTrace = forceOn & traceDeny;
  end

endmodule

// File: rtl/cpt_trap_dp.sv
module cpt_trap_dp
  import cpt_pkg::*;
#(
  parameter int CTL_W     = 32,
  parameter int POS_FP    = 10,
  parameter int POS_SIMD  = 15,
  parameter int POS_TRACE = 20,
  parameter int POS_AMU   = 30,
  parameter int POS_ACC   = 31
) (
  input  logic [CTL_W-1:0]  trapCtl,
  input  cpt_strobe_t       stb,
  output logic              trapOut,
  output logic              kindOut,
  output logic [SYND_W-1:0] syndOut
);

  localparam int NUM_OVR = 3;
  localparam int OVR_POS [NUM_OVR] = '{POS_FP, POS_SIMD, POS_TRACE};

  logic [NUM_OVR-1:0] ovrForce;
  logic [NUM_OVR-1:0] effBit;
  logic hitFp, hitSimd, hitTrace, hitAmu, hitAcc, hit;
  logic [SYND_W-1:0] cls;
  logic ctlUnused;

  assign ovrForce = {stb.forceTrace, stb.forceSimd, stb.forceFp};

  generate
    for (genvar gi = 0; gi < NUM_OVR; gi++) begin : g_eff
      assign effBit[gi] = trapCtl[OVR_POS[gi]] | ovrForce[gi];
    end
  endgenerate

  // the copy bit and reserved bits carry no trap meaning
  assign ctlUnused = ^trapCtl;

  assign hitFp    = stb.selFp & effBit[0];
  assign hitSimd  = stb.selSimd & (effBit[0] ? 1'b1 : effBit[1]);
  assign hitTrace = stb.selTrace & effBit[2];
  assign hitAmu   = stb.selAmu & trapCtl[POS_AMU];
  assign hitAcc   = stb.selAcc & trapCtl[POS_ACC];
  assign hit      = stb.allow & (hitFp | hitSimd | hitTrace | hitAmu | hitAcc);

  always_comb begin
    cls = SYN_NONE;
    if (hitFp | hitSimd)  cls = SYN_FPSIMD;
    else if (hitTrace)    cls = stb.wide ? SYN_TRACE2 : SYN_TRACE1;
    else if (hitAmu)      cls = stb.wide ? SYN_MOVE2 : SYN_MOVE1;
    else if (hitAcc)      cls = SYN_MOVE1;
  end

  assign trapOut = hit;
  assign kindOut = hit & stb.fromHyp;
  assign syndOut = (hit & ~stb.fromHyp) ? cls : SYN_NONE;

endmodule

// File: rtl/cpt_trap_classifier.sv
module cpt_trap_classifier
  import cpt_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input  logic              nonSecure,
  input  logic [1:0]        curLevel,
  input  logic [2:0]        accClass,
  input  logic              pairXfer,
  input  logic [CTL_W-1:0]  trapCtl,
  input  logic              secLvl3Narrow,
  input  logic              cp10Grant,
  input  logic              simdDeny,
  input  logic              traceDeny,
  input  logic              lowerTrap,
  output logic              trapOut,
  output logic              kindOut,
  output logic [SYND_W-1:0] syndOut
);

  cpt_strobe_t stb;

  cpt_trap_ctrl u_ctrl (
    .nonSecure     (nonSecure),
    .curLevel      (curLevel),
    .accClass      (accClass),
    .pairXfer      (pairXfer),
    .secLvl3Narrow (secLvl3Narrow),
    .cp10Grant     (cp10Grant),
    .simdDeny      (simdDeny),
    .traceDeny     (traceDeny),
    .lowerTrap     (lowerTrap),
    .stb           (stb)
  );

  cpt_trap_dp #(.CTL_W(CTL_W)) u_dp (
    .trapCtl (trapCtl),
    .stb     (stb),
    .trapOut (trapOut),
    .kindOut (kindOut),
    .syndOut (syndOut)
  );

endmodule

// File: rtl/cpt_trap_classifier_chk.sv
module cpt_trap_classifier_chk
  import cpt_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input logic              nonSecure,
  input logic [1:0]        curLevel,
  input logic [2:0]        accClass,
  input logic              pairXfer,
  input logic [CTL_W-1:0]  trapCtl,
  input logic              secLvl3Narrow,
  input logic              cp10Grant,
  input logic              simdDeny,
  input logic              traceDeny,
  input logic              lowerTrap,
  input logic              trapOut,
  input logic              kindOut,
  input logic [SYND_W-1:0] syndOut
);

  logic chkUnused;
  assign chkUnused = ^{pairXfer, trapCtl, secLvl3Narrow, cp10Grant, simdDeny, traceDeny};

  always_comb begin
    AST_SECURE_QUIET: assert (nonSecure || (!trapOut && !kindOut && syndOut == 6'h00)); // R10
    AST_LEVEL3_QUIET: assert (curLevel != 2'd3 || !trapOut); // R10
    AST_LOWER_WINS: assert (!lowerTrap || !trapOut); // R7
    AST_HYP_UNDEF: assert (!(trapOut && curLevel == 2'd2) || (kindOut && syndOut == 6'h00)); // R8
    AST_GUEST_TRAP: assert (!(trapOut && curLevel != 2'd2) || (!kindOut && syndOut != 6'h00)); // R8
    AST_IDLE_ZERO: assert (trapOut || (!kindOut && syndOut == 6'h00)); // R10
    AST_TRACE_L0: assert (!(accClass == 3'd3 && curLevel == 2'd0) || !trapOut); // R4
    AST_ACC_L1: assert (!(accClass == 3'd5 && curLevel != 2'd1) || !trapOut); // R6
  end

endmodule

bind cpt_trap_classifier cpt_trap_classifier_chk #(.CTL_W(CTL_W)) u_chk (.*);

// File: tb/cpt_trap_classifier_tb.sv
module cpt_trap_classifier_tb;

  typedef struct packed {
    logic        ns;
    logic [1:0]  lvl;
    logic [2:0]  cls;
    logic        pair;
    logic [31:0] ctl;
    logic        e3;
    logic        ok;
    logic        sd;
    logic        td;
    logic        low;
    logic        eTrap;
    logic        eKind;
    logic [5:0]  eSynd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b1,2'd0,3'd1,1'b0,32'h00000400,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h07,4'd1},  // R1
    '{1'b1,2'd1,3'd1,1'b0,32'h00003FFF,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h07,4'd1},  // R1
    '{1'b1,2'd2,3'd1,1'b0,32'h00000400,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,6'h00,4'd8},  // R8
    '{1'b1,2'd1,3'd1,1'b0,32'h00000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd1},  // R1
    '{1'b1,2'd0,3'd2,1'b0,32'h00008000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h07,4'd2},  // R2
    '{1'b1,2'd1,3'd2,1'b0,32'h00000400,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h07,4'd2},  // R2
    '{1'b1,2'd1,3'd2,1'b0,32'h00008400,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h07,4'd2},  // R2
    '{1'b1,2'd1,3'd1,1'b0,32'h00008000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd2},  // R2
    '{1'b1,2'd1,3'd1,1'b0,32'h00000800,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd3},  // R3
    '{1'b1,2'd1,3'd2,1'b0,32'h00000800,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd3},  // R3
    '{1'b1,2'd1,3'd3,1'b0,32'h00100000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h05,4'd4},  // R4
    '{1'b1,2'd1,3'd3,1'b1,32'h00100000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h0C,4'd4},  // R4
    '{1'b1,2'd0,3'd3,1'b0,32'h00100000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd4},  // R4
    '{1'b1,2'd2,3'd3,1'b1,32'h00100000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,6'h00,4'd8},  // R8
    '{1'b1,2'd0,3'd4,1'b0,32'h40000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h03,4'd5},  // R5
    '{1'b1,2'd1,3'd4,1'b1,32'h40000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h04,4'd5},  // R5
    '{1'b1,2'd2,3'd4,1'b0,32'h40000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd5},  // R5
    '{1'b1,2'd1,3'd5,1'b0,32'h80000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,6'h03,4'd6},  // R6
    '{1'b1,2'd0,3'd5,1'b0,32'h80000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd6},  // R6
    '{1'b1,2'd2,3'd5,1'b0,32'h80000000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd6},  // R6
    '{1'b1,2'd1,3'd1,1'b0,32'h00000400,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,6'h00,4'd7},  // R7
    '{1'b1,2'd1,3'd3,1'b1,32'h00100000,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,6'h00,4'd7},  // R7
    '{1'b1,2'd1,3'd1,1'b0,32'h00000000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,6'h07,4'd9},  // R9
    '{1'b1,2'd1,3'd1,1'b0,32'h00000000,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,6'h00,4'd9},  // R9
    '{1'b1,2'd1,3'd2,1'b0,32'h00000000,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,6'h07,4'd9},  // R9
    '{1'b1,2'd1,3'd3,1'b0,32'h00000000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,6'h05,4'd9},  // R9
    '{1'b0,2'd1,3'd1,1'b0,32'h00000400,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,6'h00,4'd10}, // R10
    '{1'b1,2'd3,3'd1,1'b0,32'h00000400,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd10}, // R10
    '{1'b1,2'd1,3'd0,1'b0,32'hFFFFFFFF,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,6'h00,4'd10}, // R10
    '{1'b1,2'd1,3'd4,1'b0,32'h80100400,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,4'd5}   // R5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nonSecure, pairXfer, secLvl3Narrow, cp10Grant, simdDeny, traceDeny, lowerTrap;
  logic [1:0] curLevel;
  logic [2:0] accClass;
  logic [31:0] trapCtl;
  logic trapOut, kindOut;
  logic [5:0] syndOut;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cpt_trap_classifier u_dut (
    .nonSecure(nonSecure), .curLevel(curLevel), .accClass(accClass), .pairXfer(pairXfer),
    .trapCtl(trapCtl), .secLvl3Narrow(secLvl3Narrow), .cp10Grant(cp10Grant),
    .simdDeny(simdDeny), .traceDeny(traceDeny), .lowerTrap(lowerTrap),
    .trapOut(trapOut), .kindOut(kindOut), .syndOut(syndOut)
  );

  task automatic drive(input vec_t v);
    @(negedge clk);
    nonSecure = v.ns; curLevel = v.lvl; accClass = v.cls; pairXfer = v.pair;
    trapCtl = v.ctl; secLvl3Narrow = v.e3; cp10Grant = v.ok; simdDeny = v.sd;
    traceDeny = v.td; lowerTrap = v.low;
    #5;
  endtask

  task automatic expect3(input logic eT, input logic eK, input logic [5:0] eS, input string tag);
    checks++;
    if (trapOut !== eT || kindOut !== eK || syndOut !== eS) begin
      errors++;
      $display("FAIL %s: got trap=%0b kind=%0b synd=%02h, expected trap=%0b kind=%0b synd=%02h",
               tag, trapOut, kindOut, syndOut, eT, eK, eS);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, got hang, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v;
    v = '0;
    v.ok = 1'b1;
    drive(v);
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #5;
    expect3(1'b0, 1'b0, 6'h00, "R10 idle after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      expect3(VECS[i].eTrap, VECS[i].eKind, VECS[i].eSynd, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R3: bit 11 toggled against every class, level and width
    for (int c = 0; c < 6; c++) begin
      for (int l = 0; l < 4; l++) begin
        for (int p = 0; p < 2; p++) begin
          logic t0, k0;
          logic [5:0] s0;
          v = '0; v.ns = 1'b1; v.lvl = 2'(l); v.cls = 3'(c); v.pair = p[0]; v.ok = 1'b1;
          v.ctl = 32'hC0108400;
          drive(v);
          t0 = trapOut; k0 = kindOut; s0 = syndOut;
          v.ctl = 32'hC0108C00;
          drive(v);
          expect3(t0, k0, s0, $sformatf("R3 bit11 set cls=%0d lvl=%0d", c, l));
        end
      end
    end

    // R9: a forced bit traps at level 0 too; without the qualifier nothing is forced
    v = '0; v.ns = 1'b1; v.lvl = 2'd0; v.cls = 3'd2; v.e3 = 1'b1; v.ok = 1'b0;
    drive(v);
    expect3(1'b1, 1'b0, 6'h07, "R9 cp10 forces SIMD-only");
    v.e3 = 1'b0; v.ok = 1'b1; v.sd = 1'b1; v.cls = 3'd2;
    drive(v);
    expect3(1'b0, 1'b0, 6'h00, "R9 simd deny without qualifier");
    v.lvl = 2'd2; v.cls = 3'd3; v.e3 = 1'b1; v.td = 1'b1; v.sd = 1'b0;
    drive(v);
    expect3(1'b1, 1'b1, 6'h00, "R8 forced trace from level 2");

    // R7 on a level-2 trap; R10 secure with all bits set
    v = '0; v.ns = 1'b1; v.lvl = 2'd2; v.cls = 3'd1; v.ctl = 32'hFFFFFFFF; v.ok = 1'b1; v.low = 1'b1;
    drive(v);
    expect3(1'b0, 1'b0, 6'h00, "R7 lower trap at level 2");
    v.low = 1'b0; v.ns = 1'b0;
    for (int c = 1; c < 6; c++) begin
      v.cls = 3'(c); v.lvl = 2'd1;
      drive(v);
      expect3(1'b0, 1'b0, 6'h00, $sformatf("R10 secure cls=%0d", c));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule